// File: doc/BRIEF.md
# I2C Phase Sequencer

This block drives the clock and data lines of an open-drain I2C bus from a small program held in on-chip memory. The control bus writes each program word once. A word names the slot it goes to, says whether the slot is part of a live sequence, whether the data line is to be sampled there, the level each line should take, and which slot comes next. The block has no built-in protocol machine. Start, stop, write and read bits are all chains of line states that the control side lays out, one per slot.

A start pulse makes the engine walk the chain from slot 1. Each slot is held for a fixed number of system clocks (`TICK_DIV`), and then the engine follows the slot's link. The walk ends when the link leads to a slot that is not marked live, such as the self-looping idle slot 0. While it runs, a status output is high. Slots that ask for a sample shift the synchronized data line into a 32-bit result. The result keeps the most recent bits, with the newest bit in bit 0.

Top module: `i2c_phase_sequencer`

## Requirements
- R1: Program word fields: target slot at `prog_word[18 +: ADDR_W]`, live flag at bit 13, sample flag at bit 12, clock pull at bit 11, data pull at bit 10, link to the next slot at `prog_word[ADDR_W-1:0]`. A write with `prog_we` high stores the word in the target slot.
- R2: `scl_pull`/`sda_pull` high means the line is pulled low; low means the line is released. While the engine is not running both are 0. After reset `busy` is 0, both pulls are 0 and `rd_data` is 0.
- R3: A `start` pulse while idle raises `busy` on the next cycle and executes slot 1 first, using that slot's pull bits.
- R4: Each executed slot holds its line outputs for exactly `TICK_DIV` cycles, then the engine moves to the slot named by the link field.
- R5: When the link points to a slot whose live flag is 0, `busy` falls at the end of the current slot and both lines are released. A run through N live slots keeps `busy` high for exactly N*`TICK_DIV` cycles, and the engine stays idle afterwards.
- R6: In the last cycle of a slot with the sample flag set, the data line is captured through a two-stage synchronizer and shifted into `rd_data` from the LSB side (`rd_data <= {rd_data[30:0], bit}`). After more than 32 samples, only the last 32 are kept. With bytes received MSB first, the last byte sits in `rd_data[7:0]`.
- R7: `rd_data` is cleared when a start is accepted. Between runs it holds its value.
- R8: A program write while `busy` is high is dropped.
- R9: A `start` pulse while `busy` is high has no effect on the run or on `rd_data`.
- R10: If a program write and `start` arrive in the same idle cycle, the write is stored, but the first slot executed by that run is the content slot 1 had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Program word write strobe |
| prog_word | input | 32 | Program word (fields per R1) |
| start | input | 1 | Start pulse, begins execution at slot 1 |
| sda_in | input | 1 | Sensed level of the data line |
| busy | output | 1 | High while the engine is walking a chain |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| rd_data | output | 32 | Sampled data shift register |

## Verification
Two things can share a cycle here: loading the program and launching the engine. The bench writes slot 1 and raises `start` in the same idle cycle. It then checks that the first slot executed still drives the old line levels, and that the next run shows the new ones. The bench also targets the busy window. A write that would turn the final slot into a self-loop arrives mid-run, and so does a second start pulse. Each is judged by the exact `busy` length and by the final `rd_data`. A cycle-by-cycle model checks every output on every clock. That model includes the synchronizer delay on the sampled data line, and a simple slave in the bench drives that line.

// File: rtl/i2cseq_pkg.sv
// Package: shared field positions and slot type for the I2C phase sequencer.
// Assumes the link field fits below the data-pull bit (at most 10 bits).
package i2cseq_pkg;
    localparam int WORD_W   = 32;
    localparam int POS_SLOT = 18;
    localparam int POS_LIVE = 13;
    localparam int POS_SAMP = 12;
    localparam int POS_NSCL = 11;
    localparam int POS_NSDA = 10;
    localparam int LINK_W   = 10;

    typedef struct packed {
        logic              live;
        logic              samp;
        logic              nscl;
        logic              nsda;
        logic [LINK_W-1:0] link;
    } slot_t;

    // Pulls the stored fields out of a program word.
    function automatic slot_t unpack_slot(input logic [WORD_W-1:0] w);
        slot_t s;
        s.live = w[POS_LIVE];
        s.samp = w[POS_SAMP];
        s.nscl = w[POS_NSCL];
        s.nsda = w[POS_NSDA];
        s.link = w[LINK_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/i2cseq_store.sv
// Module: slot store. Holds 2**ADDR_W program slots, with one write port and
// one combinational read port.
// Assumes the caller gates the write enable (no writes while running).
module i2cseq_store
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  slot_t             wr_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output slot_t             rd_slot
);
    localparam int DEPTH = 1 << ADDR_W;

    slot_t slots [DEPTH];

    // Store one slot per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_slot;
        end
    end

    // Read the slot the walker asks for.
    assign rd_slot = slots[rd_addr];
endmodule

// File: rtl/i2cseq_walker.sv
// Module: chain walker. Starts at slot 1 on an accepted start and holds each
// slot for TICK_DIV cycles. It then follows the link, and stops when the
// linked slot is not live. It also flags the sample cycle.
// Assumes fetch_i is the store content at fetch_addr_o in the same cycle.
module i2cseq_walker
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int TICK_DIV = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  slot_t             fetch_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              running_o,
    output slot_t             cur_o,
    output logic              launch_o,
    output logic              strobe_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(TICK_DIV - 1);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(1);

    logic             running_q;
    logic [CNT_W-1:0] cnt_q;
    slot_t            cur_q;
    logic             period_end;

    assign launch_o     = start_i & ~running_q;
    assign period_end   = running_q & (cnt_q == LAST);
    assign fetch_addr_o = running_q ? cur_q.link[ADDR_W-1:0] : FIRST;
    assign strobe_o     = period_end & cur_q.samp;
    assign running_o    = running_q;
    assign cur_o        = cur_q;

    // Launch, hold each slot, advance along the chain, or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            cur_q     <= '0;
        end else if (launch_o) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
            cur_q     <= fetch_i;
        end else if (period_end) begin
            cnt_q <= '0;
            if (fetch_i.live) begin
                cur_q <= fetch_i;
            end else begin
                running_q <= 1'b0;
                cur_q     <= '0;
            end
        end else if (running_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_q != LAST) |=> $stable(cur_q));

    // R3
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_q) |-> $past(start_i));
endmodule

// File: rtl/i2cseq_rxshift.sv
// Module: receive path. Synchronizes the data line in two stages and shifts
// one bit in on each strobe. The register clears when a run is launched.
// Assumes strobe and clear never fall in the same cycle.
module i2cseq_rxshift #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              clear_i,
    input  logic              strobe_i,
    output logic [DATA_W-1:0] data_o
);
    logic              s1_q, s2_q;
    logic [DATA_W-1:0] data_q;

    // Two-stage synchronizer for the sensed data line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= sda_i;
            s2_q <= s1_q;
        end
    end

    // Clear on launch, shift left on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (clear_i) begin
            data_q <= '0;
        end else if (strobe_i) begin
            data_q <= {data_q[DATA_W-2:0], s2_q};
        end
    end

    assign data_o = data_q;

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (data_q == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !clear_i) |=> $stable(data_q));
endmodule

// File: rtl/i2c_phase_sequencer.sv
// Module: top of the I2C phase sequencer. Program words go into the slot store
// while the engine is idle. The walker steps through the slots, and the
// receive path collects the sampled bits.
// Assumes ADDR_W <= 10 and that the line pulls are wired to open-drain pads.
module i2c_phase_sequencer
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int TICK_DIV = 125,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [31:0]       prog_word,
    input  logic              start,
    input  logic              sda_in,
    output logic              busy,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [DATA_W-1:0] rd_data
);
    logic              running;
    logic              launch;
    logic              strobe;
    logic              wr_en;
    logic [ADDR_W-1:0] fetch_addr;
    slot_t             fetch_slot;
    slot_t             cur_slot;
    logic              unused_word;

    assign unused_word = ^prog_word;
    assign wr_en       = prog_we & ~running;

    i2cseq_store #(.ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (prog_word[POS_SLOT +: ADDR_W]),
        .wr_slot (unpack_slot(prog_word)),
        .rd_addr (fetch_addr),
        .rd_slot (fetch_slot)
    );

    i2cseq_walker #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) walker_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .fetch_i      (fetch_slot),
        .fetch_addr_o (fetch_addr),
        .running_o    (running),
        .cur_o        (cur_slot),
        .launch_o     (launch),
        .strobe_o     (strobe)
    );

    i2cseq_rxshift #(.DATA_W(DATA_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_i    (sda_in),
        .clear_i  (launch),
        .strobe_i (strobe),
        .data_o   (rd_data)
    );

    assign busy     = running;
    assign scl_pull = running & cur_slot.nscl;
    assign sda_pull = running & cur_slot.nsda;
endmodule

// File: tb/i2c_phase_sequencer_tb.sv
module i2c_phase_sequencer_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [31:0] prog_word = '0;
    logic        start = 1'b0;
    logic        sda_in;
    logic        busy, scl_pull, sda_pull;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_phase_sequencer #(.ADDR_W(10), .TICK_DIV(DIV), .DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_word(prog_word),
        .start(start), .sda_in(sda_in), .busy(busy), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .rd_data(rd_data)
    );

    // simple slave: pulls data low during chosen clock-high phases
    bit slave_pull = 0;
    bit scl_prev = 0;
    int fall_idx = 0;
    bit sched[$];
    assign sda_in = ~(sda_pull | slave_pull);

    always @(negedge clk) begin
        if (!busy) begin
            fall_idx = 0;
            slave_pull = 0;
        end else if (scl_pull && !scl_prev) begin
            slave_pull = (fall_idx < sched.size()) ? sched[fall_idx] : 1'b0;
            fall_idx++;
        end
        scl_prev = scl_pull;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [31:0] mmem [1024];
    bit        m_run = 0;
    bit [31:0] m_cur = 0;
    int        m_cnt = 0;
    bit [31:0] m_rd = 0;
    bit        h1 = 1, h2 = 1;
    bit        m_ok = 0;

    always @(posedge clk) begin
        bit pre_run;
        bit [31:0] fst;
        bit [31:0] nx;
        pre_run = m_run;
        if (!rst_n) begin
            m_run = 0; m_cur = 0; m_cnt = 0; m_rd = 0; h1 = 1; h2 = 1;
        end else begin
            fst = mmem[1];
            if (m_run) begin
                if (m_cnt == DIV - 1) begin
                    if (m_cur[12]) m_rd = {m_rd[30:0], h2};
                    nx = mmem[m_cur[9:0]];
                    if (nx[13]) m_cur = nx;
                    else begin m_run = 0; m_cur = 0; end
                    m_cnt = 0;
                end else m_cnt++;
            end else if (start) begin
                m_run = 1; m_cur = fst; m_cnt = 0; m_rd = 0;
            end
            if (prog_we && !pre_run) mmem[prog_word[27:18]] = prog_word;
            h2 = h1;
            h1 = sda_in;
        end
        m_ok = 1;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (m_ok && !finished) begin
            chk(busy === m_run, "R5 busy vs model", 32'(busy), 32'(m_run));
            chk(scl_pull === (m_run & m_cur[11]), "R4 scl_pull vs model",
                32'(scl_pull), 32'(m_run & m_cur[11]));
            chk(sda_pull === (m_run & m_cur[10]), "R4 sda_pull vs model",
                32'(sda_pull), 32'(m_run & m_cur[10]));
            chk(rd_data === m_rd, "R6 rd_data vs model", rd_data, m_rd);
        end
    end

    int busy_len = 0;
    always @(negedge clk) if (busy) busy_len++;

    // program builder
    int pa = 1;

    function automatic bit [31:0] mkw(input int a, input bit live, input bit samp,
                                      input bit scl_hi, input bit sda_hi, input int nxt);
        return (32'(a) << 18) | (32'(live) << 13) | (32'(samp) << 12) |
               (32'(!scl_hi) << 11) | (32'(!sda_hi) << 10) | 32'(nxt);
    endfunction

    task automatic wr(input bit [31:0] w);
        @(negedge clk); #2;
        prog_we = 1; prog_word = w;
        @(posedge clk); #1;
        prog_we = 0;
    endtask

    task automatic put(input bit scl_hi, input bit sda_hi, input bit samp, input bit last);
        wr(mkw(pa, 1, samp, scl_hi, sda_hi, last ? 0 : pa + 1));
        pa++;
    endtask

    task automatic prog_begin();
        pa = 1;
        sched.delete();
        wr(mkw(0, 0, 0, 1, 1, 0));
    endtask

    task automatic g_start();
        put(1, 1, 0, 0); put(1, 0, 0, 0); put(0, 0, 0, 0);
    endtask

    task automatic g_wbit(input bit v, input bit pull);
        put(0, v, 0, 0); put(1, v, 0, 0); put(0, v, 0, 0);
        sched.push_back(pull);
    endtask

    task automatic g_wbyte(input bit [7:0] b);
        for (int i = 7; i >= 0; i--) g_wbit(b[i], 0);
        g_wbit(1, 1);
    endtask

    task automatic g_rbyte(input bit [7:0] b, input bit last);
        for (int i = 7; i >= 0; i--) begin
            put(0, 1, 0, 0); put(1, 1, 0, 0); put(1, 1, 1, 0); put(0, 1, 0, 0);
            sched.push_back(!b[i]);
        end
        g_wbit(last, 0);
    endtask

    task automatic g_stop();
        put(0, 0, 0, 0); put(1, 0, 0, 0); put(1, 1, 0, 1);
        sched.push_back(0);
    endtask

    task automatic go();
        busy_len = 0;
        @(negedge clk); #2;
        start = 1;
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic finish_wait(input int n, input string tag);
        int g;
        g = 0;
        @(negedge clk);
        while (busy && g < 4000) begin
            @(negedge clk);
            g++;
        end
        #1;
        chk(busy_len == n * DIV, tag, 32'(busy_len), 32'(n * DIV));
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R2 reset busy", 32'(busy), 0);
        chk(scl_pull == 0 && sda_pull == 0, "R2 reset lines released",
            32'({scl_pull, sda_pull}), 0);
        chk(rd_data == 0, "R2 reset rd_data", rd_data, 0);

        // Program A: address byte, two read bytes
        prog_begin(); g_start(); g_wbyte(8'hA1); g_rbyte(8'hA5, 0); g_rbyte(8'h3C, 1); g_stop();
        n = pa - 1;
        go();
        @(negedge clk);
        chk(busy == 1, "R3 busy after start", 32'(busy), 1);
        chk({scl_pull, sda_pull} == 2'b00, "R1 slot1 both released",
            32'({scl_pull, sda_pull}), 0);
        repeat (DIV) @(negedge clk);
        chk({scl_pull, sda_pull} == 2'b01, "R1 slot2 data pulled",
            32'({scl_pull, sda_pull}), 1);
        repeat (DIV) @(negedge clk);
        chk({scl_pull, sda_pull} == 2'b11, "R4 slot3 both pulled",
            32'({scl_pull, sda_pull}), 3);
        finish_wait(n, "R5 busy length program A");
        chk(rd_data == 32'h0000A53C, "R6 two read bytes", rd_data, 32'h0000A53C);
        repeat (10) @(negedge clk);
        chk(busy == 0 && scl_pull == 0 && sda_pull == 0, "R5 stays idle, released",
            32'({busy, scl_pull, sda_pull}), 0);

        // Program B: four read bytes
        prog_begin(); g_start(); g_wbyte(8'hB1);
        g_rbyte(8'h12, 0); g_rbyte(8'h34, 0); g_rbyte(8'h56, 0); g_rbyte(8'h78, 1); g_stop();
        n = pa - 1;
        chk(rd_data == 32'h0000A53C, "R7 result held between runs", rd_data, 32'h0000A53C);
        go();
        @(negedge clk);
        chk(rd_data == 0, "R7 cleared at start", rd_data, 0);
        finish_wait(n, "R5 busy length program B");
        chk(rd_data == 32'h12345678, "R6 four read bytes", rd_data, 32'h12345678);

        // Program C: five read bytes, oldest dropped
        prog_begin(); g_start(); g_wbyte(8'hC1);
        g_rbyte(8'h11, 0); g_rbyte(8'h22, 0); g_rbyte(8'h33, 0); g_rbyte(8'h44, 0);
        g_rbyte(8'h55, 1); g_stop();
        n = pa - 1;
        go();
        finish_wait(n, "R5 busy length program C");
        chk(rd_data == 32'h22334455, "R6 five bytes keep last 32 bits", rd_data, 32'h22334455);

        // R8: write during run that would loop the final slot onto itself
        prog_begin(); g_start(); g_wbyte(8'h55); g_stop();
        n = pa - 1;
        go();
        repeat (6) @(posedge clk);
        wr(mkw(n, 1, 0, 1, 1, n));
        finish_wait(n, "R8 write during run ignored");

        // R9: second start during run
        prog_begin(); g_start(); g_rbyte(8'h5A, 1); g_stop();
        n = pa - 1;
        go();
        repeat (40) @(posedge clk);
        @(negedge clk); #2 start = 1;
        @(posedge clk); #1 start = 0;
        finish_wait(n, "R9 start during run ignored");
        chk(rd_data == 32'h0000005A, "R9 result not cleared by second start",
            rd_data, 32'h5A);

        // R10: write slot 1 and start in the same cycle
        busy_len = 0;
        @(negedge clk); #2;
        prog_we = 1; prog_word = mkw(1, 1, 0, 1, 0, 2); start = 1;
        @(posedge clk); #1;
        prog_we = 0; start = 0;
        @(negedge clk);
        chk(busy == 1, "R3 busy after combined start", 32'(busy), 1);
        chk(sda_pull == 0, "R10 first slot uses old content", 32'(sda_pull), 0);
        finish_wait(n, "R10 run length with combined write");
        go();
        @(negedge clk);
        chk(sda_pull == 1, "R10 write was stored", 32'(sda_pull), 1);
        finish_wait(n, "R5 busy length after rewrite");

        repeat (5) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule